// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps wall-clock time and date: seconds, minutes, hours, day of month, month, a two-digit year and a separate century byte. It moves forward by one second each time an external one-second strobe arrives. A small control register chooses how every field is encoded, either packed decimal (BCD) or plain binary. It also chooses whether hours are kept on a 24-hour or a 12-hour dial. On the 12-hour dial, bit 7 of the hour byte marks the afternoon.

Software reaches all eight bytes through one indexed port. It sets a hold bit, loads a consistent time while the counter is frozen, then clears the hold bit so that counting resumes from the loaded value. Reads return the byte exactly as it is stored. A midnight rollover carries into the day, the month, the year and the century. Month lengths come from a fixed table, and February has 29 days in any year whose two-digit value is divisible by 4.

Top module: `cal_tod`

## Requirements
- R1: Register indices are 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year, 6 century and 7 control. Indices 8 to 15 read as 0x00. After reset the values are seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year 0x00, century 0x20 and control 0x04.
- R2: Control bit 1 set selects binary encoding for every field, and clear selects BCD. In binary, 0:59:59 advances to 1:00:00, with 59 stored as 0x3B.
- R3: In BCD mode carries are decimal. Hour 0x09, minute 0x59 and second 0x59 advance to 0x10:0x00:0x00.
- R4: Control bit 2 set selects the 24-hour dial, on which 23:59:59 advances to 00:00:00 and the day of month increments.
- R5: While control bit 0 (hold) is 1, writes are accepted and strobes do not advance any register. After hold is cleared, the next strobe advances the seconds from the loaded value.
- R6: On the 12-hour dial (control bit 2 clear), bit 7 of the hour byte is the PM flag and the low bits hold 1 to 12. In BCD, 0x11 goes to 0x92, 0x12 to 0x01, 0x92 to 0x81 and 0x91 to 0x12. In binary, 0x0B goes to 0x8C, 0x0C to 0x01, 0x8C to 0x81 and 0x8B to 0x0C.
- R7: A day carry wraps to day 1 after 31, 30 or 28 days according to the month. February has 29 days when the year value is divisible by 4. Month 12 wraps to 1 and carries into the year.
- R8: Year 99 wraps to 00 and increments the century. A write to the year register leaves the century unchanged.
- R9: A register write in the same cycle as a strobe takes effect, and that strobe is dropped for every field.
- R10: Reads return the stored byte unchanged, with no format conversion, even after the encoding mode is switched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| wr_en | input | 1 | Write the selected register this cycle |
| reg_sel | input | 4 | Register index for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Contents of the selected register (combinational) |

## Verification
The bench drives the hour byte across every 12-hour transition point in both encodings. A design that handled the PM bit or the value 12 wrongly would produce hour bytes such as 0x00, 0x13 or 0x80. It loads values one second before a decimal carry, where a binary incrementer would leave 0x0A in a BCD digit. It also walks month and year ends with and without a leap year, where a wrong table either skips February 29 or produces a day 0x29 in non-leap years. Strobes that coincide with writes or arrive under hold would show up as seconds that move when they should not.

// File: rtl/cal_tod.sv
module cal_tod #(
  parameter logic [7:0] RESET_CENTURY = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       wr_en,
  input  logic [3:0] reg_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data
);

  logic [7:0] sec_q, min_q, hr_q, day_q, mon_q, yr_q, cen_q;
  logic [2:0] ctrl_q;

  wire hold = ctrl_q[0];
  wire binm = ctrl_q[1];
  wire h24m = ctrl_q[2];

  function automatic logic [6:0] dec(input logic [7:0] v, input logic b);
    return b ? v[6:0] : 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] enc(input logic [6:0] n, input logic b);
    return b ? {1'b0, n} : {4'(n / 7'd10), 4'(n % 7'd10)};
  endfunction

  logic [6:0] s_n, m_n, h12, h_n, d_n, mo_n, y_n, c_n, mlen;
  logic [6:0] s_x, m_x, h_x, d_x, mo_x, y_x, c_x, hh;
  logic       c_s, c_m, c_h, c_d, c_mo, c_y, leap;
  logic [7:0] hr_nx, h_enc;

  always_comb begin
    s_n  = dec(sec_q, binm);
    m_n  = dec(min_q, binm);
    h12  = dec({1'b0, hr_q[6:0]}, binm);
    h_n  = h24m ? dec(hr_q, binm)
                : ((h12 >= 7'd12 ? 7'd0 : h12) + (hr_q[7] ? 7'd12 : 7'd0));
    d_n  = dec(day_q, binm);
    mo_n = dec(mon_q, binm);
    y_n  = dec(yr_q, binm);
    c_n  = dec(cen_q, binm);
    leap = (y_n[1:0] == 2'd0);
    case (mo_n)
      7'd2:                      mlen = leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   mlen = 7'd30;
      default:                   mlen = 7'd31;
    endcase

    c_s  = s_n >= 7'd59;
    c_m  = c_s && m_n >= 7'd59;
    c_h  = c_m && h_n >= 7'd23;
    c_d  = c_h && d_n >= mlen;
    c_mo = c_d && mo_n >= 7'd12;
    c_y  = c_mo && y_n >= 7'd99;

    s_x  = c_s ? 7'd0 : s_n + 7'd1;
    m_x  = c_s ? (c_m ? 7'd0 : m_n + 7'd1) : m_n;
    h_x  = c_m ? (c_h ? 7'd0 : h_n + 7'd1) : h_n;
    d_x  = c_h ? (c_d ? 7'd1 : d_n + 7'd1) : d_n;
    mo_x = c_d ? (c_mo ? 7'd1 : mo_n + 7'd1) : mo_n;
    y_x  = c_mo ? (c_y ? 7'd0 : y_n + 7'd1) : y_n;
    c_x  = c_y ? (c_n >= 7'd99 ? 7'd0 : c_n + 7'd1) : c_n;

    hh    = h_x % 7'd12;
    h_enc = enc((hh == 7'd0) ? 7'd12 : hh, binm);
    hr_nx = h24m ? enc(h_x, binm) : {h_x >= 7'd12, h_enc[6:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hr_q   <= 8'h00;
      day_q  <= 8'h01;
      mon_q  <= 8'h01;
      yr_q   <= 8'h00;
      cen_q  <= RESET_CENTURY;
      ctrl_q <= 3'b100;
    end else if (wr_en) begin
      case (reg_sel)
        4'd0: sec_q  <= wr_data;
        4'd1: min_q  <= wr_data;
        4'd2: hr_q   <= wr_data;
        4'd3: day_q  <= wr_data;
        4'd4: mon_q  <= wr_data;
        4'd5: yr_q   <= wr_data;
        4'd6: cen_q  <= wr_data;
        4'd7: ctrl_q <= wr_data[2:0];
        default: ;
      endcase
    end else if (sec_tick && !hold) begin
      sec_q <= enc(s_x, binm);
      min_q <= enc(m_x, binm);
      hr_q  <= hr_nx;
      day_q <= enc(d_x, binm);
      mon_q <= enc(mo_x, binm);
      yr_q  <= enc(y_x, binm);
      cen_q <= enc(c_x, binm);
    end
  end

  always_comb begin
    case (reg_sel)
      4'd0:    rd_data = sec_q;
      4'd1:    rd_data = min_q;
      4'd2:    rd_data = hr_q;
      4'd3:    rd_data = day_q;
      4'd4:    rd_data = mon_q;
      4'd5:    rd_data = yr_q;
      4'd6:    rd_data = cen_q;
      4'd7:    rd_data = {5'd0, ctrl_q};
      default: rd_data = 8'h00;
    endcase
  end

endmodule

// File: rtl/cal_tod_chk.sv
module cal_tod_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_tick,
  input logic       wr_en,
  input logic [3:0] reg_sel,
  input logic [7:0] wr_data,
  input logic [2:0] ctrl,
  input logic [7:0] sec,
  input logic [7:0] mnt,
  input logic [7:0] hr,
  input logic [7:0] cen
);

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !wr_en) |=> ($stable(sec) && $stable(mnt) && $stable(hr) && $stable(cen)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && !wr_en) |=> ($stable(sec) && $stable(mnt) && $stable(hr) && $stable(cen)));

  assert_century_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 4'd5) |=> $stable(cen));

  assert_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel != 4'd0) |=> $stable(sec));

  assert_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 4'd0) |=> (sec == $past(wr_data)));

endmodule

bind cal_tod cal_tod_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
  .reg_sel(reg_sel), .wr_data(wr_data), .ctrl(ctrl_q),
  .sec(sec_q), .mnt(min_q), .hr(hr_q), .cen(cen_q)
);

// File: tb/cal_tod_tb_top.sv
module cal_tod_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] reg_sel = 4'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;

  int checks = 0;
  int failures = 0;
  int mdl [16];
  bit live = 0;

  always #4 clk = ~clk;

  cal_tod dut_i (.clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
                 .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data));

  function automatic int dv(int v);
    return (mdl[7] & 2) ? v : ((v >> 4) * 10 + (v & 15));
  endfunction
  function automatic int ev(int n);
    return (mdl[7] & 2) ? n : (((n / 10) << 4) | (n % 10));
  endfunction
  function automatic int days_in(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic mdl_advance();
    int s = dv(mdl[0]), m = dv(mdl[1]), h, d = dv(mdl[3]);
    int mo = dv(mdl[4]), y = dv(mdl[5]), c = dv(mdl[6]);
    bit twelve = (mdl[7] & 4) == 0;
    if (twelve) h = (dv(mdl[2] & 127) % 12) + ((mdl[2] & 128) ? 12 : 0);
    else h = dv(mdl[2]);
    s++;
    if (s == 60) begin s = 0; m++; end
    if (m == 60) begin m = 0; h++; end
    if (h == 24) begin h = 0; d++; end
    if (d > days_in(mo, y)) begin d = 1; mo++; end
    if (mo == 13) begin mo = 1; y++; end
    if (y == 100) begin y = 0; c = (c + 1) % 100; end
    mdl[0] = ev(s); mdl[1] = ev(m); mdl[3] = ev(d);
    mdl[4] = ev(mo); mdl[5] = ev(y); mdl[6] = ev(c);
    if (twelve) mdl[2] = ev((h % 12 == 0) ? 12 : h % 12) | ((h >= 12) ? 128 : 0);
    else mdl[2] = ev(h);
  endtask

  task automatic cycle(bit we, int sel, int wd, bit tk);
    @(negedge clk); #1;
    if (live) begin
      checks++;
      if (rd_data !== 8'(mdl[reg_sel])) begin
        failures++;
        $display("FAIL R10 model compare idx %0d actual %h expected %h", reg_sel, rd_data, 8'(mdl[reg_sel]));
      end
    end
    wr_en = we; reg_sel = 4'(sel); wr_data = 8'(wd); sec_tick = tk;
    @(posedge clk);
    if (we) begin
      if (sel < 7) mdl[sel] = wd & 255;
      else if (sel == 7) mdl[7] = wd & 7;
    end else if (tk && !(mdl[7] & 1)) mdl_advance();
  endtask

  task automatic chk(string tag, int idx, int exp);
    @(negedge clk);
    wr_en = 0; sec_tick = 0; reg_sel = 4'(idx); #1;
    checks++;
    if (rd_data !== 8'(exp)) begin
      failures++;
      $display("FAIL %s idx %0d actual %h expected %h", tag, idx, rd_data, 8'(exp));
    end
  endtask

  task automatic load(int ctl, int h, int m, int s, int d, int mo, int y, int c);
    cycle(1, 7, ctl | 1, 0);
    cycle(1, 2, h, 0); cycle(1, 1, m, 0); cycle(1, 0, s, 0);
    cycle(1, 3, d, 0); cycle(1, 4, mo, 0); cycle(1, 5, y, 0); cycle(1, 6, c, 0);
    cycle(1, 7, ctl, 0);
  endtask

  task automatic hour_step(string tag, int ctl, int h, int exp);
    load(ctl, h, (ctl & 2) ? 59 : 'h59, (ctl & 2) ? 59 : 'h59, 1, 1, 1, 'h20);
    cycle(0, 2, 0, 1);
    chk(tag, 2, exp);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = 0;
    mdl[3] = 1; mdl[4] = 1; mdl[6] = 'h20; mdl[7] = 4;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    live = 1;
    chk("R1", 0, 0); chk("R1", 1, 0); chk("R1", 2, 0); chk("R1", 3, 1);
    chk("R1", 4, 1); chk("R1", 5, 0); chk("R1", 6, 'h20); chk("R1", 7, 4); chk("R1", 9, 0);

    load(4, 'h09, 'h59, 'h59, 'h05, 'h06, 'h11, 'h20);
    cycle(0, 0, 0, 1);
    chk("R3", 2, 'h10); chk("R3", 1, 'h00); chk("R3", 0, 'h00);

    cycle(1, 7, 5, 0);
    cycle(1, 0, 'h41, 0);
    repeat (3) cycle(0, 0, 0, 1);
    chk("R5", 0, 'h41); chk("R5", 2, 'h10);
    cycle(1, 7, 4, 0);
    cycle(0, 0, 0, 1);
    chk("R5", 0, 'h42);

    load(4, 'h23, 'h59, 'h59, 'h05, 'h06, 'h11, 'h20);
    cycle(0, 0, 0, 1);
    chk("R4", 2, 'h00); chk("R4", 0, 'h00); chk("R4", 3, 'h06);

    hour_step("R6", 0, 'h11, 'h92);
    hour_step("R6", 0, 'h12, 'h01);
    hour_step("R6", 0, 'h92, 'h81);
    hour_step("R6", 0, 'h91, 'h12);
    hour_step("R6 R2", 2, 'h0B, 'h8C);
    hour_step("R6 R2", 2, 'h0C, 'h01);
    hour_step("R6 R2", 2, 'h8C, 'h81);
    hour_step("R6 R2", 2, 'h8B, 'h0C);

    load(6, 0, 58, 59, 1, 1, 1, 20);
    cycle(0, 0, 0, 1);
    chk("R2", 1, 'h3B); chk("R2", 0, 'h00);
    load(6, 0, 59, 59, 1, 1, 1, 20);
    cycle(0, 0, 0, 1);
    chk("R2", 2, 'h01); chk("R2", 1, 'h00);

    load(4, 'h23, 'h59, 'h59, 'h28, 'h02, 'h23, 'h20);
    cycle(0, 0, 0, 1);
    chk("R7", 3, 'h01); chk("R7", 4, 'h03);
    load(4, 'h23, 'h59, 'h59, 'h28, 'h02, 'h24, 'h20);
    cycle(0, 0, 0, 1);
    chk("R7", 3, 'h29); chk("R7", 4, 'h02);
    repeat (86400 / 1000) cycle(0, 0, 0, 0);
    load(4, 'h23, 'h59, 'h59, 'h30, 'h04, 'h24, 'h20);
    cycle(0, 0, 0, 1);
    chk("R7", 3, 'h01); chk("R7", 4, 'h05);
    load(4, 'h23, 'h59, 'h59, 'h31, 'h12, 'h99, 'h19);
    cycle(0, 0, 0, 1);
    chk("R8", 5, 'h00); chk("R8", 6, 'h20); chk("R7", 4, 'h01); chk("R7", 3, 'h01);

    cycle(1, 5, 'h47, 0);
    chk("R8", 6, 'h20); chk("R8", 5, 'h47);

    load(4, 'h10, 'h20, 'h59, 'h01, 'h01, 'h00, 'h20);
    cycle(1, 0, 'h30, 1);
    chk("R9", 0, 'h30); chk("R9", 1, 'h20);
    cycle(1, 3, 'h09, 1);
    chk("R9", 0, 'h30); chk("R9", 3, 'h09);

    cycle(1, 0, 'h45, 0);
    cycle(1, 7, 6, 0);
    chk("R10", 0, 'h45); chk("R10", 7, 6);

    repeat (4) cycle(0, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule